// File: doc/BRIEF.md
# Masked Interrupt Aggregator With Acknowledge

The block gathers up to eight interrupt request lines into one level output for an upstream chip-level interrupt controller. Hardware sources raise requests with a one-cycle set vector and withdraw them with a one-cycle clear vector. A pending register records every posted source. An enable register decides which pending sources reach the output.

Software reaches the block through byte-wide register writes. The enable is written in inverted form, so a 0 bit in the written byte lets that source through. An acknowledge write drops one pending bit, selected by number. The pending register can be read back through a 64-bit-wide read port.

A second, cascaded controller slot is decoded only so that its accesses are harmless. Its mask writes change nothing, and its reads return zero. The output is held in a tracking flip-flop. An upstream post or withdraw happens only when the flag actually changes, so each request is signalled exactly once.

Top module: `irq_agg`

## Requirements
- R1: After reset the pending register and the enable register are all zeros, so every source is disabled, and `irq_o` is low.
- R2: A write to address 0 stores the bitwise inverse of `reg_wdata_i` as the enable vector. A read of address 0 returns that enable vector, zero-extended.
- R3: `irq_o` rises on the clock edge that completes the mask write or post strobe which first leaves a pending and enabled source. It is visible one clock after the strobe is sampled.
- R4: `irq_o` falls on the clock edge that completes the mask write, clear strobe or acknowledge which leaves no pending and enabled source.
- R5: A non-zero `src_post_i` vector is ORed into the pending register at the next clock edge, whatever the enable vector holds.
- R6: Every bit set in `src_clr_i` is cleared from the pending register at the next clock edge.
- R7: A write to address 2 clears the pending bit whose index is `reg_wdata_i[3:0]`. Bits 7:4 of the data are ignored. An index of 8 or above changes nothing.
- R8: When a bit is posted in the same cycle as it is cleared, by vector or by acknowledge, the clear wins.
- R9: A write to address 1 (secondary mask) or address 3 changes neither the enable, the pending register nor `irq_o`. Reads of addresses 1 and 2 return zero.
- R10: A read of address 3 returns the pending register in bits 7:0 and zeros in bits 63:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Write address: 0 primary mask, 1 secondary mask, 2 acknowledge, 3 none |
| reg_wdata_i | input | 8 | Write data byte |
| rd_addr_i | input | 2 | Read address: 0 enable, 1 and 2 zero, 3 pending |
| rd_data_o | output | 64 | Combinational read data |
| src_post_i | input | 8 | Source request set vector, one-cycle pulse |
| src_clr_i | input | 8 | Source request clear vector, one-cycle pulse |
| irq_o | output | 1 | Registered level interrupt to the upstream controller |

## Verification
The assertions assume that all strobes and vectors are synchronous to `clk_i` and hold known values after reset. They also assume that only one register write is presented per cycle. The rise check for `irq_o` only triggers in cycles with no register write and no clear. This keeps it from guessing how simultaneous mask, acknowledge and clear traffic will resolve. The bench drives every input on the falling edge and lowers each strobe after a single rising edge. It only overlaps post with clear, or post with acknowledge, in the scenario that is deliberately aimed at R8.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    ADDR_MASK_PRI = 2'd0,
    ADDR_MASK_SEC = 2'd1,
    ADDR_ACK      = 2'd2,
    ADDR_PEND     = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_agg_mask.sv
module irq_agg_mask #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_d_o,
  output logic [NUM_SRC-1:0] en_q_o
);
  logic [NUM_SRC-1:0] en_q;

  // stored inverted: a written 0 enables the source
  assign en_d_o = wr_en_i ? ~wdata_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d_o;
  end

  assign en_q_o = en_q;
endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ACK_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] post_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               ack_wr_i,
  input  logic [ACK_W-1:0]   ack_idx_i,
  output logic [NUM_SRC-1:0] pend_d_o,
  output logic [NUM_SRC-1:0] pend_q_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] ack_hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    assign ack_hit[k]  = ack_wr_i && (ack_idx_i == ACK_W'(k));
    // clear and acknowledge take precedence over a same-cycle post
    assign pend_d_o[k] = (pend_q[k] | post_i[k]) & ~clr_i[k] & ~ack_hit[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d_o;
  end

  assign pend_q_o = pend_q;
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_d_i,
  input  logic [NUM_SRC-1:0] en_d_i,
  output logic               irq_o
);
  logic active_q;
  logic any_d;

  assign any_d = |(pend_d_i & en_d_i);

  // tracking flag: only toggles on a real change, one post/withdraw each
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 active_q <= 1'b0;
    else if (any_d && !active_q) active_q <= 1'b1;
    else if (!any_d && active_q) active_q <= 1'b0;
  end

  assign irq_o = active_q;
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned RD_W    = 64
) (
  input  logic [1:0]         rd_addr_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [RD_W-1:0]    rd_data_o
);
  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      ADDR_MASK_PRI: rd_data_o = RD_W'(en_i);
      ADDR_PEND:     rd_data_o = RD_W'(pend_i);
      default:       rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RD_W    = 64,
  parameter int unsigned ACK_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic [1:0]         rd_addr_i,
  output logic [RD_W-1:0]    rd_data_o,
  input  logic [NUM_SRC-1:0] src_post_i,
  input  logic [NUM_SRC-1:0] src_clr_i,
  output logic               irq_o
);
  logic               mask_wr;
  logic               ack_wr;
  logic [NUM_SRC-1:0] en_d, en_q;
  logic [NUM_SRC-1:0] pend_d, pend_q;

  // secondary mask and address 3 are decoded to nothing
  assign mask_wr = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_MASK_PRI);
  assign ack_wr  = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_ACK);

  irq_agg_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (mask_wr),
    .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
    .en_d_o  (en_d),
    .en_q_o  (en_q)
  );

  irq_agg_pend #(.NUM_SRC(NUM_SRC), .ACK_W(ACK_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .post_i    (src_post_i),
    .clr_i     (src_clr_i),
    .ack_wr_i  (ack_wr),
    .ack_idx_i (reg_wdata_i[ACK_W-1:0]),
    .pend_d_o  (pend_d),
    .pend_q_o  (pend_q)
  );

  irq_agg_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_d_i (pend_d),
    .en_d_i   (en_d),
    .irq_o    (irq_o)
  );

  irq_agg_rdmux #(.NUM_SRC(NUM_SRC), .RD_W(RD_W)) u_rd (
    .rd_addr_i (rd_addr_i),
    .en_i      (en_q),
    .pend_i    (pend_q),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RD_W    = 64,
  parameter int unsigned ACK_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_wr_i,
  input logic [1:0]         reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [1:0]         rd_addr_i,
  input logic [RD_W-1:0]    rd_data_o,
  input logic [NUM_SRC-1:0] src_post_i,
  input logic [NUM_SRC-1:0] src_clr_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] en_q
);
  logic               wr_mask, wr_ack;
  logic [NUM_SRC-1:0] ack_oh;

  assign wr_mask = reg_wr_i && (reg_addr_i == 2'd0);
  assign wr_ack  = reg_wr_i && (reg_addr_i == 2'd2);
  always_comb begin
    ack_oh = '0;
    for (int k = 0; k < NUM_SRC; k++)
      if (reg_wdata_i[ACK_W-1:0] == ACK_W'(k)) ack_oh[k] = wr_ack;
  end

  a_r2_mask_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> en_q == ~$past(reg_wdata_i[NUM_SRC-1:0]));

  a_r3_post_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(src_post_i & en_q)) && src_clr_i == '0 && !reg_wr_i) |=> irq_o);

  a_r4_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(pend_q & en_q));

  a_r5_post_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_post_i != '0 && !wr_ack) |=>
      (pend_q & $past(src_post_i & ~src_clr_i)) == $past(src_post_i & ~src_clr_i));

  a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_clr_i != '0 |=> (pend_q & $past(src_clr_i)) == '0);

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oh != '0 |=> (pend_q & $past(ack_oh)) == '0);

  a_r9_sec_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i == 2'd1 |-> rd_data_o == '0);

  a_r10_wide_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i == 2'd3 |-> rd_data_o == RD_W'(pend_q));
endmodule

bind irq_agg irq_agg_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .RD_W(RD_W), .ACK_W(ACK_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .src_post_i(src_post_i), .src_clr_i(src_clr_i), .irq_o(irq_o),
  .pend_q(pend_q), .en_q(en_q)
);

// File: tb/tb_irq_agg.sv
`timescale 1ns/1ps
module tb_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [1:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [7:0]  post = '0;
  logic [7:0]  clr = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_agg dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .src_post_i(post), .src_clr_i(clr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    post   = '0;
    clr    = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(2'd0, v); chk("R1 enable", v, 64'h0);
    rd(2'd3, v); chk("R1 pending", v, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
    rd(2'd2, v); chk("R9 ack addr reads zero", v, 64'h0);
  endtask

  task automatic t_post_masked();
    logic [63:0] v;
    post = 8'h05; step();
    rd(2'd3, v); chk("R5 post while masked", v, 64'h05);
    chk("R5 irq stays low", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_mask();
    logic [63:0] v;
    wr(2'd0, 8'hFE);
    rd(2'd0, v); chk("R2 inverted enable", v, 64'h01);
    chk("R3 irq after mask write", {63'h0, irq}, 64'h1);
    wr(2'd0, 8'hFF);
    chk("R4 irq after masking", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_ack();
    logic [63:0] v;
    wr(2'd0, 8'hFE);
    wr(2'd2, 8'h00);
    rd(2'd3, v); chk("R7 ack bit 0", v, 64'h04);
    chk("R4 irq after ack", {63'h0, irq}, 64'h0);
    wr(2'd2, 8'hF2);
    rd(2'd3, v); chk("R7 upper data bits ignored", v, 64'h00);
    post = 8'h80; step();
    wr(2'd2, 8'h0F);
    rd(2'd3, v); chk("R7 index 15 no effect", v, 64'h80);
    wr(2'd2, 8'h08);
    rd(2'd3, v); chk("R7 index 8 no effect", v, 64'h80);
  endtask

  task automatic t_clear();
    logic [63:0] v;
    wr(2'd0, 8'h7F);
    chk("R3 irq on enable of pending bit 7", {63'h0, irq}, 64'h1);
    clr = 8'h80; step();
    rd(2'd3, v); chk("R6 clear vector", v, 64'h00);
    chk("R4 irq after clear", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_conflict();
    logic [63:0] v;
    post = 8'h03; clr = 8'h01; step();
    rd(2'd3, v); chk("R8 clear beats post", v, 64'h02);
    post = 8'h01; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00; step();
    rd(2'd3, v); chk("R8 ack beats post", v, 64'h02);
  endtask

  task automatic t_secondary();
    logic [63:0] v;
    wr(2'd1, 8'h00);
    rd(2'd0, v); chk("R9 secondary write keeps enable", v, 64'h80);
    chk("R9 secondary write no irq", {63'h0, irq}, 64'h0);
    rd(2'd1, v); chk("R9 secondary reads zero", v, 64'h0);
    wr(2'd3, 8'h00);
    rd(2'd0, v); chk("R9 addr 3 write keeps enable", v, 64'h80);
    rd(2'd3, v); chk("R9 addr 3 write keeps pending", v, 64'h02);
  endtask

  task automatic t_wide();
    logic [63:0] v;
    post = 8'hFF; step();
    rd(2'd3, v); chk("R10 wide pending read", v, 64'h0000_0000_0000_00FF);
    chk("R3 irq after post of enabled bit", {63'h0, irq}, 64'h1);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post_masked();
    t_mask();
    t_ack();
    t_clear();
    t_conflict();
    t_secondary();
    t_wide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule